// File: doc/BRIEF.md
# Clocked Synchronous FIFO Serial Transmitter

This block is the transmit half of a clocked synchronous serial port. A host pushes bytes into a 16-entry transmit FIFO. The shifter takes them one at a time and sends each one as an 8-bit frame, least significant bit first. There are no start, stop or parity bits. The serial clock comes from one of two places: an internal divider of the system clock, or an external clock input that the block follows.

Frames follow one another with no gap for as long as the FIFO holds data. The FIFO is polled while the last bit of a frame is on the line. When it is found empty, the block raises an end-of-transmission flag and leaves the data line at the last bit it sent. A selectable trigger level drives a FIFO-low flag, which can be routed to an interrupt request. Clear strobes let the host acknowledge the FIFO-low flag and the end flag. A write to a full FIFO is thrown away and sets a sticky overflow flag.

Top module: `sync_ser_tx`

## Requirements
- R1: The FIFO holds up to 16 bytes. `fifo_count` reports the occupancy. A write while the FIFO is not full is accepted, and the count includes it from the next clock.
- R2: A write while `fifo_count` is 16 is dropped. It sets `overflow`, which stays at 1 until reset, whatever clear strobes arrive. The dropped byte is never transmitted.
- R3: `trig_sel` codes 0, 1, 2 and 3 select trigger levels 0, 2, 4 and 8. `fifo_low` is set in the clock after `fifo_count` is at or below the level. `clr_low` clears it only while the count is above the level; otherwise the flag reasserts.
- R4: `tx_irq` equals `fifo_low` while `irq_en` is 1 and is 0 while `irq_en` is 0.
- R5: Each frame is 8 bits sent LSB first. `txd` changes only when the serial clock falls, so it is stable at each rising edge.
- R6: While bytes remain, a new frame starts on the falling edge right after the previous bit 7. The rising edges of a burst stay evenly spaced.
- R7: With `ext_clk` at 0, `sclk_out` gives exactly 8 low pulses per byte. Each half period lasts `half_div`+1 system clocks.
- R8: With `ext_clk` at 1, bits are shifted on the edges of `sclk_in`, sampled through a two-stage synchronizer, and `sclk_out` stays high. No bit leaves while `sclk_in` is static.
- R9: When the FIFO is empty at the last-bit check, `tx_end` rises at the end of that bit, and `txd` keeps the value of bit 7.
- R10: `tx_end` is cleared by a `clr_end` pulse or by an accepted write.
- R11: With `clk_run` at 0, `sclk_out` rests high whenever no frame is in progress. With `clk_run` at 1 in internal mode, it toggles continuously.
- R12: After reset, `txd`=1, `sclk_out`=1, `tx_end`=1, `fifo_low`=1, `overflow`=0 and `fifo_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the transmit FIFO |
| wr_data | input | 8 | Byte to enqueue |
| trig_sel | input | 2 | Trigger level select (0, 2, 4, 8 bytes) |
| irq_en | input | 1 | Transmit interrupt enable |
| clr_low | input | 1 | Clear strobe for `fifo_low` |
| clr_end | input | 1 | Clear strobe for `tx_end` |
| ext_clk | input | 1 | 1 = follow `sclk_in`, 0 = internal divider |
| clk_run | input | 1 | 1 = internal clock runs while idle |
| half_div | input | DIV_W | Half-period of the internal clock minus one, in system clocks |
| sclk_in | input | 1 | External serial clock |
| txd | output | 1 | Serial data |
| sclk_out | output | 1 | Serial clock output |
| fifo_count | output | $clog2(DEPTH)+1 | FIFO occupancy |
| fifo_low | output | 1 | FIFO at or below trigger level |
| tx_end | output | 1 | Shifter ran dry |
| overflow | output | 1 | Sticky write-to-full flag |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Writes and clear strobes show up at `fifo_count`, `tx_end` and `overflow` at the first clock edge after the strobe. `fifo_low` settles one edge after the count does, so the bench waits two cycles after a write or a clear before it compares any flag. In internal mode, `txd` moves on the same edge on which `sclk_out` falls. In external mode it moves about three system clocks after `sclk_in` falls, which is well inside the six-clock half period the bench uses. The bench captures data only at rising serial-clock edges and samples everything at the falling system-clock edge. Wherever the exact cycle is not fixed, it polls `tx_end` against a bound before it compares the bytes it collected.

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  input  logic [1:0]               trig_sel,
  input  logic                     irq_en,
  input  logic                     clr_low,
  input  logic                     clr_end,
  input  logic                     ext_clk,
  input  logic                     clk_run,
  input  logic [DIV_W-1:0]         half_div,
  input  logic                     sclk_in,
  output logic                     txd,
  output logic                     sclk_out,
  output logic [$clog2(DEPTH):0]   fifo_count,
  output logic                     fifo_low,
  output logic                     tx_end,
  output logic                     overflow,
  output logic                     tx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop;

  wire wr_ok     = wr_en && (cnt != FULL);
  wire has_data  = (cnt != '0);
  wire [7:0] head = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LAST_SLOT) ? '0 : wp + 1'b1;
      if (pop)   rp <= (rp == LAST_SLOT) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(pop);
    end
  end

  logic [DIV_W-1:0] dcnt;
  logic             ph;
  logic [2:0]       sy;

  wire tick = !ext_clk && (dcnt >= half_div);

  always_ff @(posedge clk) begin
    if (!rst_n || ext_clk) begin
      dcnt <= '0;
      ph   <= 1'b1;
    end else if (tick) begin
      dcnt <= '0;
      ph   <= ~ph;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sy <= 3'b111;
    else        sy <= {sy[1:0], sclk_in};
  end

  wire fall_ev = ext_clk ? (sy[2] & ~sy[1]) : (tick & ph);
  wire rise_ev = ext_clk ? (~sy[2] & sy[1]) : (tick & ~ph);

  logic [7:0] sh;
  logic [2:0] bidx;
  logic       busy, cont;

  wire last    = busy && (bidx == 3'd7);
  wire end_set = fall_ev && last && !cont;

  assign pop = has_data && ((fall_ev && !busy) || (rise_ev && last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      bidx <= '0;
      busy <= 1'b0;
      cont <= 1'b0;
      txd  <= 1'b1;
    end else begin
      if (rise_ev && last) begin
        cont <= has_data;
        if (has_data) sh <= head;
      end
      if (fall_ev) begin
        if (!busy) begin
          if (has_data) begin
            sh   <= head;
            txd  <= head[0];
            bidx <= '0;
            busy <= 1'b1;
          end
        end else if (!last) begin
          txd  <= sh[bidx + 3'd1];
          bidx <= bidx + 3'd1;
        end else if (cont) begin
          txd  <= sh[0];
          bidx <= '0;
          cont <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end

  logic [CW-1:0] lvl;
  assign lvl = (trig_sel == 2'd0) ? '0 : (CW'(1) << trig_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_low <= 1'b1;
      tx_end   <= 1'b1;
      overflow <= 1'b0;
    end else begin
      fifo_low <= (cnt <= lvl) | (fifo_low & ~clr_low);
      tx_end   <= (tx_end | end_set) & ~(clr_end | wr_ok);
      overflow <= overflow | (wr_en & ~wr_ok);
    end
  end

  assign fifo_count = cnt;
  assign tx_irq     = fifo_low & irq_en;
  assign sclk_out   = ext_clk ? 1'b1 : ((busy | clk_run) ? ph : 1'b1);

endmodule

// File: rtl/sync_ser_tx_chk.sv
module sync_ser_tx_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [1:0]             trig_sel,
  input logic                   irq_en,
  input logic                   ext_clk,
  input logic                   clk_run,
  input logic                   txd,
  input logic                   sclk_out,
  input logic [$clog2(DEPTH):0] fifo_count,
  input logic                   fifo_low,
  input logic                   tx_end,
  input logic                   overflow,
  input logic                   tx_irq
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic [CW-1:0] lvl;
  always_comb begin
    case (trig_sel)
      2'd0:    lvl = CW'(0);
      2'd1:    lvl = CW'(2);
      2'd2:    lvl = CW'(4);
      default: lvl = CW'(8);
    endcase
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));
  p_write_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_count < CW'(DEPTH)) |=> (fifo_count != '0));
  p_drop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_count == CW'(DEPTH)) |=> overflow);
  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_low_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count <= lvl) |=> fifo_low);
  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !tx_irq);
  p_txd_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk && $stable(ext_clk) && !$stable(txd)) |-> $fell(sclk_out));
  p_end_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> $stable(txd));
  p_end_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_count < CW'(DEPTH)) |=> !tx_end);
  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && !clk_run && !ext_clk) |-> sclk_out);
endmodule

bind sync_ser_tx sync_ser_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .trig_sel(trig_sel),
  .irq_en(irq_en), .ext_clk(ext_clk), .clk_run(clk_run), .txd(txd),
  .sclk_out(sclk_out), .fifo_count(fifo_count), .fifo_low(fifo_low),
  .tx_end(tx_end), .overflow(overflow), .tx_irq(tx_irq)
);

// File: tb/sync_ser_tx_test.sv
`timescale 1ns/1ps
module sync_ser_tx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] trig_sel = '0;
  logic irq_en = 1'b0, clr_low = 1'b0, clr_end = 1'b0;
  logic ext_clk = 1'b0, clk_run = 1'b0, sclk_in = 1'b1;
  logic [7:0] half_div = 8'd1;
  logic txd, sclk_out, fifo_low, tx_end, overflow, tx_irq;
  logic [4:0] fifo_count;

  sync_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .trig_sel(trig_sel), .irq_en(irq_en), .clr_low(clr_low), .clr_end(clr_end),
    .ext_clk(ext_clk), .clk_run(clk_run), .half_div(half_div), .sclk_in(sclk_in),
    .txd(txd), .sclk_out(sclk_out), .fifo_count(fifo_count), .fifo_low(fifo_low),
    .tx_end(tx_end), .overflow(overflow), .tx_irq(tx_irq));

  always #10 clk = ~clk;

  int nvec = 0, nerr = 0, cyc = 0;

  // fields: [10:9] trig_sel, [8] irq_en, [7:3] writes, [2] low, [1] irq, [0] ovf
  localparam int NV = 11;
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 1'b1, 5'd0,  3'b110},
    {2'd0, 1'b1, 5'd1,  3'b000},
    {2'd1, 1'b0, 5'd2,  3'b100},
    {2'd1, 1'b1, 5'd3,  3'b000},
    {2'd2, 1'b1, 5'd4,  3'b110},
    {2'd2, 1'b1, 5'd5,  3'b000},
    {2'd3, 1'b1, 5'd8,  3'b110},
    {2'd3, 1'b0, 5'd9,  3'b000},
    {2'd3, 1'b1, 5'd16, 3'b000},
    {2'd0, 1'b1, 5'd17, 3'b001},
    {2'd2, 1'b0, 5'd20, 3'b001}
  };

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: captures bits at rising serial clock edges
  logic       prev_src = 1'b1, src_m;
  logic [7:0] shreg = '0;
  logic [7:0] cap [32];
  int cap_n = 0, nb = 0, falls = 0, gap_err = 0, last_rise = -1, period = 4;
  bit mon_en = 0, gap_on = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    src_m = ext_clk ? sclk_in : sclk_out;
    if (mon_en) begin
      if (src_m && !prev_src) begin
        shreg = {txd, shreg[7:1]};
        nb++;
        if (nb == 8) begin
          if (cap_n < 32) cap[cap_n] = shreg;
          cap_n++;
          nb = 0;
        end
        if (gap_on && last_rise >= 0 && (cyc - last_rise) != period) gap_err++;
        last_rise = cyc;
      end
      if (!src_m && prev_src) falls++;
    end
    prev_src = src_m;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  task automatic mon_clear(input bit gaps, input int per);
    @(negedge clk); #1;
    cap_n = 0; nb = 0; falls = 0; gap_err = 0; last_rise = -1;
    period = per; gap_on = gaps; mon_en = 1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_low();
    @(negedge clk); clr_low = 1'b1;
    @(negedge clk); clr_low = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 4000 && !tx_end; i++) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 txd", txd, 1);
    chk("R12 sclk_out", sclk_out, 1);
    chk("R12 tx_end", tx_end, 1);
    chk("R12 fifo_low", fifo_low, 1);
    chk("R12 overflow", overflow, 0);
    chk("R12 fifo_count", fifo_count, 0);

    // table: trigger levels, interrupt gating, occupancy, overflow
    for (int i = 0; i < NV; i++) begin
      int n;
      n = int'(VEC[i][7:3]);
      ext_clk = 1'b1; sclk_in = 1'b1;
      do_reset();
      trig_sel = VEC[i][10:9]; irq_en = VEC[i][8];
      for (int k = 0; k < n; k++) put(8'(k + 1));
      repeat (2) @(negedge clk);
      pulse_low();
      repeat (2) @(negedge clk);
      chk("R3 fifo_low after clear", fifo_low, int'(VEC[i][2]));
      chk("R4 tx_irq", tx_irq, int'(VEC[i][1]));
      chk("R2 overflow", overflow, int'(VEC[i][0]));
      chk("R1 fifo_count", fifo_count, (n > 16) ? 16 : n);
    end

    // R2: overflow sticky against clears, dropped byte never sent
    do_reset();
    for (int k = 0; k < 17; k++) put(8'(k * 7 + 3));
    @(negedge clk); clr_low = 1'b1; clr_end = 1'b1;
    @(negedge clk); clr_low = 1'b0; clr_end = 1'b0;
    @(negedge clk);
    chk("R2 overflow sticky", overflow, 1);
    chk("R2 count at full", fifo_count, 16);
    half_div = 8'd0;
    mon_clear(1, 2);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    wait_end();
    chk("R2 frames sent", cap_n, 16);
    chk("R2 last sent byte", cap[15], 15 * 7 + 3);
    chk("R6 no gap at full speed", gap_err, 0);
    mon_en = 0;

    // internal clock burst: LSB first, back-to-back, pulse count, hold
    ext_clk = 1'b0; clk_run = 1'b0; half_div = 8'd1;
    do_reset();
    mon_clear(1, 4);
    put(8'hA5);
    chk("R10 write clears tx_end", tx_end, 0);
    put(8'h3C);
    put(8'h4E);
    wait_end();
    chk("R9 tx_end after burst", tx_end, 1);
    chk("R5 frame count", cap_n, 3);
    chk("R5 byte0", cap[0], 8'hA5);
    chk("R5 byte1", cap[1], 8'h3C);
    chk("R5 byte2", cap[2], 8'h4E);
    chk("R6 even rising edges", gap_err, 0);
    chk("R7 eight pulses per byte", falls, 24);
    chk("R9 txd holds bit 7", txd, 0);
    repeat (20) @(negedge clk);
    chk("R11 clock rests high", sclk_out, 1);
    chk("R9 txd still held", txd, 0);
    chk("R1 fifo drained", fifo_count, 0);

    // R7: slower divider, single frame
    half_div = 8'd3;
    mon_clear(1, 8);
    put(8'h96);
    wait_end();
    chk("R7 byte at divider 3", cap[0], 8'h96);
    chk("R7 half period divider 3", gap_err, 0);
    chk("R7 pulses single byte", falls, 8);
    chk("R9 txd holds bit 7 high", txd, 1);

    // R10 clear strobe
    @(negedge clk); clr_end = 1'b1;
    @(negedge clk); clr_end = 1'b0;
    @(negedge clk);
    chk("R10 clr_end clears", tx_end, 0);

    // external clock mode
    mon_en = 0;
    ext_clk = 1'b1; sclk_in = 1'b1;
    put(8'h5A);
    put(8'hC3);
    repeat (10) @(negedge clk);
    chk("R8 no shift without clock", fifo_count, 2);
    chk("R8 txd idle without clock", txd, 1);
    chk("R8 sclk_out high", sclk_out, 1);
    mon_clear(0, 12);
    for (int p = 0; p < 18; p++) begin
      @(negedge clk); #1 sclk_in = 1'b0;
      repeat (6) @(negedge clk);
      #1 sclk_in = 1'b1;
      repeat (5) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R8 ext frames", cap_n, 2);
    chk("R8 ext byte0", cap[0], 8'h5A);
    chk("R8 ext byte1", cap[1], 8'hC3);
    chk("R9 ext tx_end", tx_end, 1);
    mon_en = 0;

    // R11 free-running idle clock
    ext_clk = 1'b0; clk_run = 1'b1; half_div = 8'd2;
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!sclk_out) lows++;
      end
      chk("R11 idle clock toggles", (lows > 0) ? 1 : 0, 1);
      chk("R11 txd unchanged while idle", txd, 1);
      clk_run = 1'b0;
      lows = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!sclk_out) lows++;
      end
      chk("R11 idle clock stops", lows, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule